// File: doc/BRIEF.md
# Two-Channel Memory Copy Engine

This block moves data from one memory location to another without processor help. Software loads each of its two channels with a source address, a destination address, a unit count and a mode word. It then sets the global enable. A channel copies unit by unit over a single memory master port. Each unit is a read followed by a write, 1, 2 or 4 bytes wide. A 16-byte unit is split into four 32-bit read/write pairs.

A channel either runs freely until its count is used up, or moves one unit each time its request input is seen high while the engine is idle. When a channel finishes, it sets its end flag. If its interrupt enable is set, it also emits a one-cycle interrupt pulse with a level and a vector. Channel 0 always wins over channel 1.

Top module: `dual_dma_engine`

## Requirements
- R1: Registers use word addresses. Channel n occupies addresses 8n+0 (source), 8n+1 (destination), 8n+2 (count), 8n+3 (mode) and 8n+4 (vector, 7 bits). Address 16 bit 0 is the global enable, and address 17 holds the 4-bit interrupt level. After reset, every register reads 0.
- R2: Mode bit 0 enables the channel, bit 1 is the end flag and bit 9 selects free running. A channel moves data only while the global enable is 1, its enable is 1 and its end flag is 0. Setting the global enable starts a channel that is already configured.
- R3: When mode bit 9 is 0, the channel moves exactly one unit for each cycle in which its request input (dreq[n]) is high while the engine is idle.
- R4: Mode bits 11:10 select the unit: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 16 bytes. mem_size carries 0, 1 or 2 for 1, 2 or 4 bytes. Data is right-aligned and little-endian on mem_rdata and mem_wdata.
- R5: Bit 15 decrements the destination by the unit size and bit 14 increments it. Bits 13 and 12 do the same for the source. With neither bit set, the address stays fixed.
- R6: A 16-byte unit makes four 32-bit read/write pairs at offsets 0, 4, 8 and 12. After the unit, the source rises by 16, the destination steps by 16 in its selected direction and the count falls by 4. No access ever uses mem_size 3.
- R7: Any other unit size lowers the count by 1. Only the low 24 bits of a count write are kept. A channel started with count 0 completes without any memory access.
- R8: Completion sets the end flag. The channel then stays idle, even with its enable still set, until software rewrites the mode word with the flag cleared.
- R9: On completion with mode bit 2 set, irq_valid pulses for one cycle with no memory access pending. The pulse carries irq_vector from that channel's vector register and irq_level from the level register.
- R10: When both channels are ready, channel 0 is served until it completes.
- R11: mem_req stays high with a stable address and direction until mem_ack. Each accepted read is followed at once by the write of the same unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dreq | input | 2 | Per-channel transfer request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_size | output | 2 | Access width code |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, taken with mem_ack |
| mem_ack | input | 1 | Access complete |
| irq_valid | output | 1 | Completion interrupt pulse |
| irq_level | output | 4 | Interrupt level |
| irq_vector | output | 7 | Interrupt vector |

## Verification
With memory that acknowledges one cycle after a request, a 1/2/4-byte unit takes six cycles: one to grant, two to read, two to write and one to update. A 16-byte unit takes eighteen. The interrupt pulse arrives in the update cycle, and the new address, count and end-flag values can be read back one cycle later. The bench samples on the falling edge: every accepted write and interrupt is compared in order against a queue of predicted items. After each scenario, the bench waits a window well beyond the longest transfer and then checks that nothing predicted is missing and nothing unpredicted appeared.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int NUM_CH = 2;
    localparam int CHW    = $clog2(NUM_CH);
    localparam int DW     = 32;
    localparam int RAW    = 5;
    localparam int CTL_W  = 16;
    localparam int VEC_W  = 7;
    localparam int LVL_W  = 4;

    // mode word bit positions
    localparam int B_EN   = 0;
    localparam int B_END  = 1;
    localparam int B_IRQ  = 2;
    localparam int B_FREE = 9;

    localparam logic [2:0] F_SRC = 3'd0;
    localparam logic [2:0] F_DST = 3'd1;
    localparam logic [2:0] F_CNT = 3'd2;
    localparam logic [2:0] F_CTL = 3'd3;
    localparam logic [2:0] F_VEC = 3'd4;
    localparam logic [3:0] G_OP  = 4'd0;
    localparam logic [3:0] G_LVL = 4'd1;

    typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR, MV_UPD} mv_state_e;

    typedef struct packed {
        logic [1:0] dst_mode;
        logic [1:0] src_mode;
        logic [1:0] unit;
        logic       irq_en;
    } chan_mode_t;

    function automatic logic [4:0] unit_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd2;
            2'd2:    return 5'd4;
            default: return 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [RAW-1:0]               wr_addr,
    input  logic [DW-1:0]                wr_data,
    input  logic [RAW-1:0]               rd_addr,
    output logic [DW-1:0]                rd_data,
    input  logic                         upd_valid,
    input  logic [CHW-1:0]               upd_ch,
    input  logic [AW-1:0]                upd_src,
    input  logic [AW-1:0]                upd_dst,
    input  logic [CW-1:0]                upd_cnt,
    input  logic                         upd_end,
    output logic [NUM_CH-1:0][AW-1:0]    src_o,
    output logic [NUM_CH-1:0][AW-1:0]    dst_o,
    output logic [NUM_CH-1:0][CW-1:0]    cnt_o,
    output chan_mode_t [NUM_CH-1:0]      mode_o,
    output logic [NUM_CH-1:0]            en_o,
    output logic [NUM_CH-1:0]            end_o,
    output logic [NUM_CH-1:0]            free_o,
    output logic [NUM_CH-1:0][VEC_W-1:0] vec_o,
    output logic                         gen_o,
    output logic [LVL_W-1:0]             lvl_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][AW-1:0]    src;
        logic [NUM_CH-1:0][AW-1:0]    dst;
        logic [NUM_CH-1:0][CW-1:0]    cnt;
        logic [NUM_CH-1:0][CTL_W-1:0] ctl;
        logic [NUM_CH-1:0][VEC_W-1:0] vec;
        logic                         gen;
        logic [LVL_W-1:0]             lvl;
    } regs_t;

    regs_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            if (!wr_addr[RAW-1]) begin
                case (wr_addr[2:0])
                    F_SRC: rf_d.src[wr_addr[3]] = AW'(wr_data);
                    F_DST: rf_d.dst[wr_addr[3]] = AW'(wr_data);
                    F_CNT: rf_d.cnt[wr_addr[3]] = wr_data[CW-1:0];
                    F_CTL: rf_d.ctl[wr_addr[3]] = wr_data[CTL_W-1:0];
                    F_VEC: rf_d.vec[wr_addr[3]] = wr_data[VEC_W-1:0];
                    default: ;
                endcase
            end else begin
                case (wr_addr[3:0])
                    G_OP:  rf_d.gen = wr_data[0];
                    G_LVL: rf_d.lvl = wr_data[LVL_W-1:0];
                    default: ;
                endcase
            end
        end
        // engine results take precedence over a same-cycle software write
        if (upd_valid) begin
            rf_d.src[upd_ch] = upd_src;
            rf_d.dst[upd_ch] = upd_dst;
            rf_d.cnt[upd_ch] = upd_cnt;
            if (upd_end) rf_d.ctl[upd_ch][B_END] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rd_data = '0;
        if (!rd_addr[RAW-1]) begin
            case (rd_addr[2:0])
                F_SRC: rd_data = DW'(rf_q.src[rd_addr[3]]);
                F_DST: rd_data = DW'(rf_q.dst[rd_addr[3]]);
                F_CNT: rd_data = DW'(rf_q.cnt[rd_addr[3]]);
                F_CTL: rd_data = DW'(rf_q.ctl[rd_addr[3]]);
                F_VEC: rd_data = DW'(rf_q.vec[rd_addr[3]]);
                default: ;
            endcase
        end else begin
            case (rd_addr[3:0])
                G_OP:  rd_data = DW'(rf_q.gen);
                G_LVL: rd_data = DW'(rf_q.lvl);
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign src_o[i]           = rf_q.src[i];
        assign dst_o[i]           = rf_q.dst[i];
        assign cnt_o[i]           = rf_q.cnt[i];
        assign vec_o[i]           = rf_q.vec[i];
        assign en_o[i]            = rf_q.ctl[i][B_EN];
        assign end_o[i]           = rf_q.ctl[i][B_END];
        assign free_o[i]          = rf_q.ctl[i][B_FREE];
        assign mode_o[i].dst_mode = rf_q.ctl[i][15:14];
        assign mode_o[i].src_mode = rf_q.ctl[i][13:12];
        assign mode_o[i].unit     = rf_q.ctl[i][11:10];
        assign mode_o[i].irq_en   = rf_q.ctl[i][B_IRQ];
    end

    assign gen_o = rf_q.gen;
    assign lvl_o = rf_q.lvl;
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dma_pkg::*;
(
    input  logic              gen,
    input  logic [NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0] ended,
    input  logic [NUM_CH-1:0] free,
    input  logic [NUM_CH-1:0] dreq,
    input  logic              busy,
    output logic              grant_valid,
    output logic [CHW-1:0]    grant_ch
);
    logic [NUM_CH-1:0] ready;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ready
        assign ready[i] = gen & en[i] & ~ended[i] & (free[i] | dreq[i]);
    end

    // lowest index wins: scan from the top so channel 0 is written last
    always_comb begin
        grant_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ready[i]) grant_ch = CHW'(i);
        end
    end

    assign grant_valid = ~busy & (|ready);
endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      grant_valid,
    input  logic [CHW-1:0]            grant_ch,
    input  logic [NUM_CH-1:0][AW-1:0] src_i,
    input  logic [NUM_CH-1:0][AW-1:0] dst_i,
    input  logic [NUM_CH-1:0][CW-1:0] cnt_i,
    input  chan_mode_t [NUM_CH-1:0]   mode_i,
    output logic                      busy,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [1:0]                mem_size,
    output logic [AW-1:0]             mem_addr,
    output logic [DW-1:0]             mem_wdata,
    input  logic [DW-1:0]             mem_rdata,
    input  logic                      mem_ack,
    output logic                      upd_valid,
    output logic [CHW-1:0]            upd_ch,
    output logic [AW-1:0]             upd_src,
    output logic [AW-1:0]             upd_dst,
    output logic [CW-1:0]             upd_cnt,
    output logic                      upd_end,
    output logic                      irq_fire
);
    localparam logic [1:0] LAST_BEAT = 2'd3;

    typedef struct packed {
        mv_state_e      st;
        logic [CHW-1:0] ch;
        logic [1:0]     beat;
        logic [DW-1:0]  data;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [CW-1:0]  cnt;
        chan_mode_t     mode;
        logic           done;
    } mv_t;

    mv_t mv_d, mv_q;
    logic          burst;
    logic [AW-1:0] step;
    logic [CW-1:0] dec;
    logic [AW-1:0] offs;

    assign burst = (mv_q.mode.unit == 2'd3);
    assign step  = AW'(unit_bytes(mv_q.mode.unit));
    assign dec   = burst ? CW'(4) : CW'(1);
    assign offs  = AW'({mv_q.beat, 2'b00});

    always_comb begin
        mv_d = mv_q;
        case (mv_q.st)
            MV_IDLE: begin
                if (grant_valid) begin
                    mv_d.ch   = grant_ch;
                    mv_d.src  = src_i[grant_ch];
                    mv_d.dst  = dst_i[grant_ch];
                    mv_d.cnt  = cnt_i[grant_ch];
                    mv_d.mode = mode_i[grant_ch];
                    mv_d.beat = '0;
                    if (cnt_i[grant_ch] == '0) begin
                        mv_d.done = 1'b1;
                        mv_d.st   = MV_UPD;
                    end else begin
                        mv_d.done = 1'b0;
                        mv_d.st   = MV_RD;
                    end
                end
            end
            MV_RD: begin
                if (mem_ack) begin
                    mv_d.data = mem_rdata;
                    mv_d.st   = MV_WR;
                end
            end
            MV_WR: begin
                if (mem_ack) begin
                    if (burst && mv_q.beat != LAST_BEAT) begin
                        mv_d.beat = mv_q.beat + 2'd1;
                        mv_d.st   = MV_RD;
                    end else begin
                        if (burst)
                            mv_d.src = mv_q.src + step;
                        else
                            mv_d.src = mv_q.src
                                     - (mv_q.mode.src_mode[1] ? step : '0)
                                     + (mv_q.mode.src_mode[0] ? step : '0);
                        mv_d.dst  = mv_q.dst
                                  - (mv_q.mode.dst_mode[1] ? step : '0)
                                  + (mv_q.mode.dst_mode[0] ? step : '0);
                        mv_d.done = (mv_q.cnt <= dec);
                        mv_d.cnt  = (mv_q.cnt <= dec) ? '0 : mv_q.cnt - dec;
                        mv_d.st   = MV_UPD;
                    end
                end
            end
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mv_q <= '0;
        else        mv_q <= mv_d;
    end

    assign busy      = (mv_q.st != MV_IDLE);
    assign mem_req   = (mv_q.st == MV_RD) || (mv_q.st == MV_WR);
    assign mem_we    = (mv_q.st == MV_WR);
    assign mem_size  = burst ? 2'd2 : mv_q.mode.unit;
    assign mem_addr  = ((mv_q.st == MV_WR) ? mv_q.dst : mv_q.src) + offs;
    assign mem_wdata = mv_q.data;
    assign upd_valid = (mv_q.st == MV_UPD);
    assign upd_ch    = mv_q.ch;
    assign upd_src   = mv_q.src;
    assign upd_dst   = mv_q.dst;
    assign upd_cnt   = mv_q.cnt;
    assign upd_end   = mv_q.done;
    assign irq_fire  = (mv_q.st == MV_UPD) && mv_q.done && mv_q.mode.irq_en;
endmodule

// File: rtl/dual_dma_engine.sv
module dual_dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NUM_CH-1:0] dreq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_size,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ack,
    output logic             irq_valid,
    output logic [LVL_W-1:0] irq_level,
    output logic [VEC_W-1:0] irq_vector
);
    logic [NUM_CH-1:0][AW-1:0]    src, dst;
    logic [NUM_CH-1:0][CW-1:0]    cnt;
    chan_mode_t [NUM_CH-1:0]      mode;
    logic [NUM_CH-1:0]            en, ended, free;
    logic [NUM_CH-1:0][VEC_W-1:0] vec;
    logic                         gen;
    logic [LVL_W-1:0]             lvl;
    logic                         busy, grant_valid;
    logic [CHW-1:0]               grant_ch, upd_ch;
    logic                         upd_valid, upd_end, irq_fire;
    logic [AW-1:0]                upd_src, upd_dst;
    logic [CW-1:0]                upd_cnt;

    dma_regfile #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .rd_addr(reg_addr), .rd_data(reg_rdata),
        .upd_valid(upd_valid), .upd_ch(upd_ch), .upd_src(upd_src),
        .upd_dst(upd_dst), .upd_cnt(upd_cnt), .upd_end(upd_end),
        .src_o(src), .dst_o(dst), .cnt_o(cnt), .mode_o(mode),
        .en_o(en), .end_o(ended), .free_o(free), .vec_o(vec),
        .gen_o(gen), .lvl_o(lvl)
    );

    dma_arbiter u_arb (
        .gen(gen), .en(en), .ended(ended), .free(free), .dreq(dreq),
        .busy(busy), .grant_valid(grant_valid), .grant_ch(grant_ch)
    );

    dma_mover #(.AW(AW), .CW(CW)) u_mover (
        .clk(clk), .rst_n(rst_n),
        .grant_valid(grant_valid), .grant_ch(grant_ch),
        .src_i(src), .dst_i(dst), .cnt_i(cnt), .mode_i(mode),
        .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .upd_valid(upd_valid), .upd_ch(upd_ch), .upd_src(upd_src),
        .upd_dst(upd_dst), .upd_cnt(upd_cnt), .upd_end(upd_end),
        .irq_fire(irq_fire)
    );

    assign irq_valid  = irq_fire;
    assign irq_level  = lvl;
    assign irq_vector = vec[upd_ch];
endmodule

// File: rtl/dual_dma_engine_chk.sv
module dual_dma_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [1:0]  mem_size,
    input logic [31:0] mem_addr,
    input logic        irq_valid
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> mem_req && mem_we);

    // R6
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_size != 2'd3);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R9
    irq_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !mem_req);
endmodule

bind dual_dma_engine dual_dma_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_size(mem_size), .mem_addr(mem_addr),
    .irq_valid(irq_valid)
);

// File: tb/sim_dual_dma_engine.sv
module sim_dual_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  dreq = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        irq_valid;
    logic [3:0]  irq_level;
    logic [6:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    typedef struct { int addr; int sz; logic [31:0] data; } wr_item_t;
    typedef struct { int vec; int lvl; } irq_item_t;
    wr_item_t  wr_q[$];
    irq_item_t irq_q[$];
    logic [7:0] mem_b [0:1023];

    always #10 clk = ~clk;

    dual_dma_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .irq_valid(irq_valid), .irq_level(irq_level),
        .irq_vector(irq_vector)
    );

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 11) ^ (k >> 3));
    endfunction

    function automatic int nbytes(int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_data(int a, int sz);
        logic [31:0] v = '0;
        for (int i = 0; i < nbytes(sz); i++) v[i*8 +: 8] = pat(a + i);
        return v;
    endfunction

    initial begin
        for (int k = 0; k < 1024; k++) mem_b[k] = pat(k);
    end

    // memory model: one-cycle acknowledge, little-endian, right-aligned data
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack && !mem_we)
                for (int i = 0; i < 4; i++)
                    mem_rdata[i*8 +: 8] <= (i < nbytes(int'(mem_size)))
                        ? mem_b[(int'(mem_addr[9:0]) + i) % 1024] : 8'h00;
            if (mem_req && mem_ack && mem_we)
                for (int i = 0; i < nbytes(int'(mem_size)); i++)
                    mem_b[(int'(mem_addr[9:0]) + i) % 1024] <= mem_wdata[i*8 +: 8];
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ack) begin
            checks++;
            if (wr_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected write addr=%h data=%h expected none", tag, mem_addr, mem_wdata);
            end else begin
                wr_item_t it;
                logic [31:0] m;
                it = wr_q.pop_front();
                m = (it.sz == 0) ? 32'hFF : (it.sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
                if (mem_addr != 32'(it.addr) || int'(mem_size) != it.sz || (mem_wdata & m) != it.data) begin
                    errors++;
                    $display("FAIL %s write addr=%h size=%0d data=%h expected addr=%h size=%0d data=%h",
                             tag, mem_addr, mem_size, mem_wdata & m, it.addr, it.sz, it.data);
                end
            end
        end
        if (rst_n && irq_valid) begin
            checks++;
            if (irq_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected irq vec=%h lvl=%h expected none", tag, irq_vector, irq_level);
            end else begin
                irq_item_t ii;
                ii = irq_q.pop_front();
                if (int'(irq_vector) != ii.vec || int'(irq_level) != ii.lvl) begin
                    errors++;
                    $display("FAIL %s irq vec=%h lvl=%h expected vec=%h lvl=%h",
                             tag, irq_vector, irq_level, ii.vec, ii.lvl);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = 5'(a);
        #1;
        check(reg_rdata == exp, req, $sformatf("reg[%0d]", a), reg_rdata, exp);
    endtask

    task automatic push_wr(input int dst, input int sz, input int src);
        wr_item_t it;
        it.addr = dst; it.sz = sz; it.data = exp_data(src, sz);
        wr_q.push_back(it);
    endtask

    task automatic push_irq(input int v, input int l);
        irq_item_t it;
        it.vec = v; it.lvl = l;
        irq_q.push_back(it);
    endtask

    task automatic settle(input string req, input int n);
        repeat (n) @(negedge clk);
        check(wr_q.size() == 0 && irq_q.size() == 0, req, "pending predicted items",
              32'(wr_q.size() + irq_q.size()), 32'd0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        tag = "R1";
        rd_chk(3, 32'h0, "R1");
        rd_chk(2, 32'h0, "R1");
        rd_chk(16, 32'h0, "R1");
        rd_chk(17, 32'h0, "R1");
        wr(16, 32'h1);
        wr(17, 32'hF5);

        // R2 R5 R7 R9: 32-bit units, both incrementing, count high byte dropped
        tag = "R7";
        wr(0, 32'h010); wr(1, 32'h200); wr(2, 32'hFF00_0003); wr(4, 32'h1C5);
        rd_chk(2, 32'h3, "R7");
        tag = "R5";
        push_wr(32'h200, 2, 32'h10); push_wr(32'h204, 2, 32'h14); push_wr(32'h208, 2, 32'h18);
        push_irq(32'h45, 5);
        wr(3, 32'h5A05);
        settle("R9", 100);
        rd_chk(2, 32'h0, "R7");
        rd_chk(0, 32'h1C, "R5");
        rd_chk(1, 32'h20C, "R5");
        rd_chk(3, 32'h5A07, "R8");

        // R8 end flag keeps the channel idle
        tag = "R8";
        settle("R8", 60);

        // R4 R5 byte units, destination decrementing, no interrupt
        tag = "R4";
        wr(0, 32'h020); wr(1, 32'h240); wr(2, 32'h2);
        push_wr(32'h240, 0, 32'h20); push_wr(32'h23F, 0, 32'h21);
        wr(3, 32'h9201);
        settle("R4", 60);
        rd_chk(1, 32'h23E, "R5");
        rd_chk(0, 32'h22, "R5");

        // R6 16-byte units
        tag = "R6";
        wr(0, 32'h040); wr(1, 32'h300); wr(2, 32'h8);
        for (int b = 0; b < 4; b++) push_wr(32'h300 + 4*b, 2, 32'h40 + 4*b);
        for (int b = 0; b < 4; b++) push_wr(32'h2F0 + 4*b, 2, 32'h50 + 4*b);
        wr(3, 32'h8E01);
        settle("R6", 120);
        rd_chk(0, 32'h60, "R6");
        rd_chk(1, 32'h2E0, "R6");
        rd_chk(2, 32'h0, "R6");

        // R4 R5 16-bit units with fixed addresses
        tag = "R5";
        wr(0, 32'h062); wr(1, 32'h280); wr(2, 32'h2);
        push_wr(32'h280, 1, 32'h62); push_wr(32'h280, 1, 32'h62);
        wr(3, 32'h0601);
        settle("R5", 60);
        rd_chk(0, 32'h62, "R5");
        rd_chk(1, 32'h280, "R5");

        // R2 global enable gates start
        tag = "R2";
        wr(16, 32'h0);
        wr(0, 32'h070); wr(1, 32'h290); wr(2, 32'h1);
        wr(3, 32'h0A01);
        settle("R2", 40);
        rd_chk(3, 32'h0A01, "R2");
        push_wr(32'h290, 2, 32'h70);
        wr(16, 32'h1);
        settle("R2", 40);

        // R3 request-driven channel 1, one unit per request
        tag = "R3";
        wr(8, 32'h080); wr(9, 32'h2A0); wr(10, 32'h2); wr(12, 32'h33);
        wr(11, 32'h5805);
        settle("R3", 30);
        push_wr(32'h2A0, 2, 32'h80);
        @(negedge clk); dreq[1] = 1'b1;
        @(negedge clk); dreq[1] = 1'b0;
        settle("R3", 30);
        rd_chk(10, 32'h1, "R3");
        push_wr(32'h2A4, 2, 32'h84);
        push_irq(32'h33, 5);
        @(negedge clk); dreq[1] = 1'b1;
        @(negedge clk); dreq[1] = 1'b0;
        settle("R3", 30);
        rd_chk(11, 32'h5807, "R8");

        // R10 channel 0 first when both are ready together
        tag = "R10";
        wr(16, 32'h0);
        wr(8, 32'h0A0); wr(9, 32'h3A0); wr(10, 32'h1); wr(11, 32'h0A01);
        wr(0, 32'h0B0); wr(1, 32'h3B0); wr(2, 32'h2); wr(3, 32'h5A01);
        push_wr(32'h3B0, 2, 32'hB0); push_wr(32'h3B4, 2, 32'hB4);
        push_wr(32'h3A0, 2, 32'hA0);
        wr(16, 32'h1);
        settle("R10", 80);

        // R7 R9 zero count completes at once with new level
        tag = "R9";
        wr(17, 32'h0A);
        wr(2, 32'h0); wr(4, 32'h7E);
        push_irq(32'h7E, 10);
        wr(3, 32'h0205);
        settle("R9", 30);
        rd_chk(3, 32'h0207, "R7");

        finish_run();
    end
endmodule